// File: doc/BRIEF.md
# SDRAM Read Burst Engine

This block is the memory-side half of a single-data-rate SDRAM read path. It watches the command pins on every rising clock edge. When it sees a READ, it captures the bank, the starting column and the auto-precharge request. It then drives one data word per cycle onto a tri-state data bus. The first word appears a configurable CAS latency of 1, 2 or 3 cycles after the command, and the words are fetched from a small internal array indexed by bank and column.

Bursts are fixed (1, 2, 4 or 8 words, sequential order inside the aligned block) or run through the whole page. A full-page burst wraps from the last column back to column 0 and keeps running until it is cut off. A new READ cuts off any running burst. Its first word follows the last wanted word of the old burst with no gap, which lets a controller stream data continuously. A burst-terminate command stops a burst without starting a new one. When a completed burst had auto-precharge requested, the block raises a one-cycle flag together with the bank number so that the row logic can close the row. The latency and the burst length are static configuration inputs.

Top module: `sdr_read_burst`

## Requirements
- R1: A READ is accepted only at a rising edge where cke=1, cs_n=0, ras_n=1, cas_n=0 and we_n=1. Any other pin combination, or cke=0, starts no burst. The one exception is the terminate code of R11.
- R2: The bank comes from ba, the start column from addr[8:0], and the auto-precharge request from addr[10]. addr[9], addr[11] and addr[12] have no effect. The word for bank b and column c is {b,14'b0} ^ c ^ (c << 7) ^ 16'hA5C3.
- R3: With cfg_cas_lat set to 1, 2 or 3, the first word (from the start column) is valid on dq at the rising edge that lies cfg_cas_lat edges after the READ edge.
- R4: cfg_burst_len codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 words. The words come one per cycle. Only the low log2(length) column bits count upward, wrapping inside the aligned block.
- R5: cfg_burst_len codes 4 to 7 select full-page bursts. The column counts up modulo 512, passes the start column again, and never stops by itself.
- R6: A READ issued while a burst runs stops the old burst after the word that is due CL-1 edges after the new READ edge. The new burst's first word follows in the very next cycle.
- R7: A READ issued on the edge after a fixed burst's final word was scheduled gives a continuous stream with no idle cycle.
- R8: dq_oe is high exactly in the cycles that carry a burst word. dq is released to high impedance whenever dq_oe is low.
- R9: For a burst that completes with addr[10]=1, ap_pulse is high for one cycle directly after the cycle that carried the final word, and ap_bank then holds the burst's bank. There is no pulse when addr[10]=0.
- R10: A burst that is truncated by a READ or stopped by terminate never raises ap_pulse, and neither does a full-page burst.
- R11: The terminate code (cke=1, cs_n=0, ras_n=1, cas_n=1, we_n=0) schedules no further words. Words due within the next CL-1 edges still appear.
- R12: While rst_n is low, dq_oe, ap_pulse and ap_bank are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; commands are decoded only when high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write-enable command pin |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address; [8:0] column, [10] auto-precharge |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 |
| cfg_burst_len | input | 3 | Burst length code (0..3 fixed, 4..7 full page) |
| dq | inout | 16 | Tri-state data bus |
| dq_oe | output | 1 | High while the block drives dq |
| ap_pulse | output | 1 | One-cycle auto-precharge request |
| ap_bank | output | 2 | Bank to precharge, valid with ap_pulse |

## Verification
The bench aims at the column wrap inside 8-word blocks and at the page boundary from 511 to 0. A design that carried into the upper column bits, or that stopped at the page end, would put wrong words on dq. Truncating READs are placed exactly CL-1 cycles before the last wanted word at every latency, and one terminate is placed on the edge where a burst's final word would have been scheduled. A latency pipe that is one stage off would show a gap or an overlap, and a design that tied the precharge flag to the command rather than to completion would pulse for bursts that never finished. Single-word bursts issued every cycle check that back-to-back precharge pulses and continuous dq_oe are both kept.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  localparam int BA_W  = 2;
  localparam int COL_W = 9;
  localparam int DQ_W  = 16;
  localparam int BL_W  = 3;

  // {ras_n, cas_n, we_n} codes the engine reacts to
  typedef enum logic [2:0] {
    OP_READ = 3'b101,
    OP_STOP = 3'b110
  } op_e;

  // one scheduled word travelling down the latency pipe
  typedef struct packed {
    logic             vld;
    logic             last;
    logic             ap;
    logic [BA_W-1:0]  bank;
    logic [COL_W-1:0] col;
  } slot_t;

  function automatic logic [DQ_W-1:0] word_of(input logic [BA_W-1:0] b,
                                              input logic [COL_W-1:0] c);
    logic [DQ_W-1:0] w;
    w = DQ_W'(c) ^ (DQ_W'(c) << 7) ^ 16'hA5C3;
    w[DQ_W-1 -: BA_W] = w[DQ_W-1 -: BA_W] ^ b;
    return w;
  endfunction

  function automatic logic is_full(input logic [BL_W-1:0] code);
    return code[BL_W-1];
  endfunction

  function automatic logic [3:0] burst_words(input logic [BL_W-1:0] code);
    return 4'd1 << code[1:0];
  endfunction

  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] cur,
                                               input logic [BL_W-1:0] code);
    logic [COL_W-1:0] mask;
    if (is_full(code)) return cur + 1'b1;
    mask = COL_W'(burst_words(code) - 4'd1);
    return (cur & ~mask) | ((cur + 1'b1) & mask);
  endfunction
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_rd_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic rd_cmd,
  output logic term_cmd
);
  logic sel;
  assign sel      = cke && !cs_n;
  assign rd_cmd   = sel && ({ras_n, cas_n, we_n} == OP_READ);
  assign term_cmd = sel && ({ras_n, cas_n, we_n} == OP_STOP);
endmodule

// File: rtl/sdr_col_seq.sv
module sdr_col_seq
  import sdr_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic             term_cmd,
  input  logic [BA_W-1:0]  cmd_bank,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_ap,
  input  logic [BL_W-1:0]  cfg_bl,
  output slot_t            issue
);
  logic             act_q, full_q, ap_q;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q;
  logic [3:0]       left_q;
  logic [COL_W-1:0] step_col;
  logic [3:0]       first_left;

  always_comb begin
    step_col   = next_col(col_q, cfg_bl);
    first_left = burst_words(cfg_bl) - 4'd1;
    issue      = '0;
    if (rd_cmd) begin
      issue.vld  = 1'b1;
      issue.last = !is_full(cfg_bl) && (first_left == 4'd0);
      issue.ap   = cmd_ap;
      issue.bank = cmd_bank;
      issue.col  = cmd_col;
    end else if (act_q && !term_cmd) begin
      issue.vld  = 1'b1;
      issue.last = !full_q && (left_q == 4'd1);
      issue.ap   = ap_q;
      issue.bank = bank_q;
      issue.col  = step_col;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      left_q <= '0;
    end else if (rd_cmd) begin
      act_q  <= is_full(cfg_bl) || (first_left != 4'd0);
      full_q <= is_full(cfg_bl);
      ap_q   <= cmd_ap;
      bank_q <= cmd_bank;
      col_q  <= cmd_col;
      left_q <= first_left;
    end else if (act_q && !term_cmd) begin
      col_q <= step_col;
      if (!full_q) begin
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) act_q <= 1'b0;
      end
    end else if (term_cmd) begin
      act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe
  import sdr_rd_pkg::*;
#(
  parameter  int MAX_CL = 3,
  localparam int CL_W   = $clog2(MAX_CL + 1),
  localparam int NSTG   = MAX_CL - 1,
  localparam int DEPTH  = 1 << (BA_W + COL_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  slot_t           issue,
  input  logic [CL_W-1:0] cfg_cl,
  output logic            out_vld,
  output logic [DQ_W-1:0] out_word,
  output logic            ap_pulse,
  output logic [BA_W-1:0] ap_bank
);
  slot_t           stg [1:NSTG];
  slot_t           tap;
  logic [DQ_W-1:0] mem [DEPTH];
  logic            fin_q;
  logic [BA_W-1:0] fin_bank;

  for (genvar k = 1; k <= NSTG; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      stg[k] <= '0;
      else if (k == 1) stg[k] <= issue;
      else             stg[k] <= stg[k-1];
    end
  end

  always_comb begin
    tap = issue;
    for (int k = 1; k <= NSTG; k++)
      if (int'(cfg_cl) == k + 1) tap = stg[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= word_of(BA_W'(i >> COL_W), COL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_word <= '0;
      fin_q    <= 1'b0;
      fin_bank <= '0;
      ap_pulse <= 1'b0;
      ap_bank  <= '0;
    end else begin
      out_vld  <= tap.vld;
      out_word <= tap.vld ? mem[{tap.bank, tap.col}] : '0;
      fin_q    <= tap.vld && tap.last && tap.ap;
      fin_bank <= tap.bank;
      ap_pulse <= fin_q;
      ap_bank  <= fin_q ? fin_bank : '0;
    end
  end
endmodule

// File: rtl/sdr_read_burst.sv
module sdr_read_burst
  import sdr_rd_pkg::*;
#(
  parameter  int ADDR_W = 13,
  parameter  int AP_BIT = 10,
  parameter  int MAX_CL = 3,
  localparam int CL_W   = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CL_W-1:0]   cfg_cas_lat,
  input  logic [BL_W-1:0]   cfg_burst_len,
  inout  wire  [DQ_W-1:0]   dq,
  output logic              dq_oe,
  output logic              ap_pulse,
  output logic [BA_W-1:0]   ap_bank
);
  logic            rd_cmd, term_cmd, out_vld;
  slot_t           issue;
  logic [DQ_W-1:0] out_word;
  logic            unused_addr_bits;

  assign unused_addr_bits = ^{addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:COL_W]};

  sdr_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .rd_cmd(rd_cmd), .term_cmd(term_cmd)
  );

  sdr_col_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .term_cmd(term_cmd),
    .cmd_bank(ba), .cmd_col(addr[COL_W-1:0]), .cmd_ap(addr[AP_BIT]),
    .cfg_bl(cfg_burst_len), .issue(issue)
  );

  sdr_lat_pipe #(.MAX_CL(MAX_CL)) u_pipe (
    .clk(clk), .rst_n(rst_n), .issue(issue), .cfg_cl(cfg_cas_lat),
    .out_vld(out_vld), .out_word(out_word),
    .ap_pulse(ap_pulse), .ap_bank(ap_bank)
  );

  assign dq_oe = out_vld;
  assign dq    = out_vld ? out_word : {DQ_W{1'bz}};
endmodule

// File: rtl/sdr_read_burst_chk.sv
module sdr_read_burst_chk
  import sdr_rd_pkg::*;
#(
  parameter  int MAX_CL = 3,
  localparam int CL_W   = $clog2(MAX_CL + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_cmd,
  input logic            out_vld,
  input logic            ap_pulse,
  input logic [BL_W-1:0] cfg_bl,
  input logic [CL_W-1:0] cfg_cl
);
  // hist[k] holds the READ decode seen k+1 edges back
  logic [MAX_CL-1:0] hist;
  logic              due;

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[MAX_CL-2:0], rd_cmd};
  end

  always_comb begin
    due = 1'b0;
    for (int k = 0; k < MAX_CL; k++)
      if (int'(cfg_cl) == k + 1) due = hist[k];
  end

  a_r3_first_word_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    due |-> out_vld);

  a_r1_drive_starts_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> due);

  a_r9_pulse_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    ap_pulse |-> $past(out_vld));

  a_r10_no_pulse_full_page: assert property (@(posedge clk) disable iff (!rst_n)
    is_full(cfg_bl) |-> !ap_pulse);
endmodule

bind sdr_read_burst sdr_read_burst_chk #(.MAX_CL(MAX_CL)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .out_vld(out_vld),
  .ap_pulse(ap_pulse), .cfg_bl(cfg_burst_len), .cfg_cl(cfg_cas_lat)
);

// File: tb/sdr_read_burst_bench.sv
module sdr_read_burst_bench;
  localparam int MAXS = 8192;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [1:0]  cfg_cl = 2'd1;
  logic [2:0]  cfg_bl = 3'd0;
  wire  [15:0] dq;
  wire         dq_oe, ap_pulse;
  wire  [1:0]  ap_bank;

  int    cyc = 0, n_chk = 0, n_fail = 0;
  bit    mon_en = 1'b0, done = 1'b0;
  string cur_tag = "R12";

  logic        e_oe [MAXS];
  logic [15:0] e_dq [MAXS];
  logic        e_ap [MAXS];
  logic [1:0]  e_bk [MAXS];

  sdr_read_burst u_sdr_read_burst (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cfg_cas_lat(cfg_cl), .cfg_burst_len(cfg_bl),
    .dq(dq), .dq_oe(dq_oe), .ap_pulse(ap_pulse), .ap_bank(ap_bank)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] exp_word(input logic [1:0] b, input logic [8:0] c);
    return {b, 14'd0} ^ {7'd0, c} ^ {c, 7'd0} ^ 16'hA5C3;
  endfunction

  function automatic int blen();
    return cfg_bl[2] ? 0 : (1 << cfg_bl[1:0]);
  endfunction

  function automatic logic [8:0] col_at(input logic [8:0] start, input int i);
    int m;
    if (cfg_bl[2]) return 9'((int'(start) + i) % 512);
    m = blen() - 1;
    return 9'((int'(start) & ~m) | ((int'(start) + i) & m));
  endfunction

  task automatic chk(input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s slot %0d: actual %h expected %h", cur_tag, what, cyc, act, exp);
    end
  endtask

  // later command cancels what was scheduled from its first data slot on
  task automatic clear_from(input int t);
    for (int s = t + int'(cfg_cl) - 1; s < MAXS; s++) e_oe[s] = 1'b0;
    for (int s = t + int'(cfg_cl); s < MAXS; s++) e_ap[s] = 1'b0;
  endtask

  task automatic model_read(input int t, input logic [1:0] b, input logic [8:0] c, input bit ap);
    int n, base;
    clear_from(t);
    base = t + int'(cfg_cl) - 1;
    n = cfg_bl[2] ? MAXS : blen();
    for (int i = 0; i < n && base + i < MAXS; i++) begin
      e_oe[base + i] = 1'b1;
      e_dq[base + i] = exp_word(b, col_at(c, i));
    end
    if (!cfg_bl[2] && ap && base + n < MAXS) begin
      e_ap[base + n] = 1'b1;
      e_bk[base + n] = b;
    end
  endtask

  task automatic send_read(input logic [1:0] b, input logic [8:0] c, input bit ap, input bit junk);
    cke = 1'b1; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
    ba = b;
    addr = {junk, junk, ap, junk, c};
    model_read(cyc + 1, b, c, ap);
    @(negedge clk);
  endtask

  task automatic send_term();
    cke = 1'b1; cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b0;
    clear_from(cyc + 1);
    @(negedge clk);
  endtask

  task automatic send_raw(input logic k, input logic [3:0] pins);
    cke = k; {cs_n, ras_n, cas_n, we_n} = pins;
    ba = 2'd2; addr = 13'h05A5;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_en && rst_n && cyc < MAXS) begin
      chk(dq_oe === e_oe[cyc], "dq_oe", 32'(dq_oe), 32'(e_oe[cyc]));
      if (e_oe[cyc]) chk(dq === e_dq[cyc], "dq", 32'(dq), 32'(e_dq[cyc]));
      chk(ap_pulse === e_ap[cyc], "ap_pulse", 32'(ap_pulse), 32'(e_ap[cyc]));
      if (e_ap[cyc]) chk(ap_bank === e_bk[cyc], "ap_bank", 32'(ap_bank), 32'(e_bk[cyc]));
    end
  end

  task automatic t_reset();
    cur_tag = "R12";
    repeat (3) @(negedge clk);
    chk(dq_oe === 1'b0, "reset dq_oe", 32'(dq_oe), 0);
    chk(ap_pulse === 1'b0, "reset ap_pulse", 32'(ap_pulse), 0);
    chk(ap_bank === 2'd0, "reset ap_bank", 32'(ap_bank), 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    idle(3);
  endtask

  task automatic t_fixed_lengths();
    cur_tag = "R3 R4 R8";
    for (int l = 1; l <= 3; l++)
      for (int code = 0; code < 4; code++) begin
        cfg_cl = 2'(l); cfg_bl = 3'(code);
        idle(2);
        send_read(2'(code), 9'h0A5, 1'b0, 1'b0);
        idle(13);
      end
  endtask

  task automatic t_addr_bits();
    cur_tag = "R2";
    cfg_cl = 2'd2; cfg_bl = 3'd2; idle(2);
    send_read(2'd3, 9'h1FE, 1'b0, 1'b1);
    idle(10);
  endtask

  task automatic t_ignored_cmds();
    cur_tag = "R1";
    cfg_cl = 2'd1; cfg_bl = 3'd3; idle(2);
    send_raw(1'b0, 4'b0101);
    send_raw(1'b1, 4'b1101);
    send_raw(1'b1, 4'b0100);
    send_raw(1'b1, 4'b0011);
    send_raw(1'b1, 4'b0001);
    idle(12);
  endtask

  task automatic t_full_page();
    cur_tag = "R5 R11";
    cfg_cl = 2'd3; cfg_bl = 3'd7; idle(2);
    send_read(2'd1, 9'h1FA, 1'b1, 1'b0);
    idle(530);
    send_term();
    idle(10);
    cur_tag = "R6 R5";
    cfg_cl = 2'd1; idle(2);
    send_read(2'd0, 9'h010, 1'b0, 1'b0);
    idle(20);
    send_read(2'd2, 9'h1FD, 1'b0, 1'b0);
    idle(8);
    send_term();
    idle(8);
  endtask

  task automatic t_truncate();
    cur_tag = "R6 R10";
    cfg_bl = 3'd3;
    for (int l = 1; l <= 3; l++) begin
      cfg_cl = 2'(l); idle(2);
      send_read(2'd1, 9'h033, 1'b1, 1'b0);
      idle(2);
      send_read(2'd2, 9'h140, 1'b1, 1'b0);
      idle(14);
    end
  endtask

  task automatic t_back_to_back();
    cur_tag = "R7 R9";
    cfg_cl = 2'd2; cfg_bl = 3'd2; idle(2);
    send_read(2'd0, 9'h00C, 1'b1, 1'b0); idle(3);
    send_read(2'd1, 9'h0F1, 1'b0, 1'b0); idle(3);
    send_read(2'd3, 9'h1FF, 1'b1, 1'b0);
    idle(10);
    cfg_cl = 2'd3; cfg_bl = 3'd0; idle(2);
    send_read(2'd1, 9'h001, 1'b1, 1'b0);
    send_read(2'd2, 9'h002, 1'b1, 1'b0);
    send_read(2'd3, 9'h003, 1'b1, 1'b0);
    idle(10);
  endtask

  task automatic t_precharge_flag();
    cur_tag = "R9";
    cfg_cl = 2'd1; cfg_bl = 3'd1; idle(2);
    send_read(2'd2, 9'h077, 1'b1, 1'b0); idle(6);
    send_read(2'd2, 9'h077, 1'b0, 1'b0); idle(6);
  endtask

  task automatic t_terminate();
    cur_tag = "R11 R10";
    cfg_cl = 2'd3; cfg_bl = 3'd3; idle(2);
    send_read(2'd3, 9'h0A0, 1'b1, 1'b0); idle(2);
    send_term(); idle(10);
    cfg_bl = 3'd2; idle(2);
    send_read(2'd1, 9'h0B2, 1'b1, 1'b0); idle(2);
    send_term(); idle(10);
    cur_tag = "R7 R10";
    send_read(2'd2, 9'h0C4, 1'b1, 1'b0); idle(3);
    send_read(2'd0, 9'h0D8, 1'b1, 1'b0); idle(10);
  endtask

  initial begin
    for (int s = 0; s < MAXS; s++) begin
      e_oe[s] = 1'b0; e_dq[s] = '0; e_ap[s] = 1'b0; e_bk[s] = '0;
    end
    @(negedge clk);
    t_reset();
    t_fixed_lengths();
    t_addr_bits();
    t_ignored_cmds();
    t_full_page();
    t_truncate();
    t_back_to_back();
    t_precharge_flag();
    t_terminate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule